// File: doc/BRIEF.md
# External Memory Bus Strobe Generator

This block produces the timing strobes and address drive for the external memory bus of a classic 8-bit microcontroller. It runs on the oscillator clock. It divides that clock into 12-clock machine cycles, and each machine cycle has two 6-clock halves. In each half it can emit one address-latch pulse (`ale`, active high) and one program-read strobe (`psen_n`, active low). While the latch pulse is high and for one clock after it, the low address byte is driven on the shared low port. After that the port is released so that it can act as the data bus. The high address byte, or the port-2 latch contents, appears on the high port.

Once per machine cycle the surrounding core tells the block what kind of cycle it is. An instruction-fetch cycle reads code twice, at the given address and at the next address, one read per half. An external data cycle presents its address only in the first half, uses either an 8-bit or a 16-bit address, and gives no program-read strobe at all. A gating input keeps the latch pulse silent except while an external move instruction is running. Instruction decode and the data transfer itself lie outside this block.

Top module: `emem_bus_strobes`

## Requirements
- R1: While `rst` is high, and in the first output state after a reset edge, `ale`=0, `psen_n`=1, `p0_oe`=0, `p0_out`=0 and `p2_out`=0. The first clock after reset is released is slot 1 of a fetch cycle at address 0.
- R2: A machine cycle lasts 12 clocks, numbered slots 0..11. In a fetch cycle `ale` is high in slots 0, 1, 6 and 7 and low in every other slot. This gives one 2-clock pulse every 6 clocks.
- R3: In an external data cycle (`cyc_xdata`=1), `ale` is high only in slots 0 and 1. The pulse in slots 6 and 7 is left out.
- R4: In a fetch cycle `psen_n` is low in slots 3–5 and 9–11 and high elsewhere. It is never low while `ale` is high.
- R5: In an external data cycle `psen_n` stays high for all 12 slots.
- R6: When `ale_off`=1 and `ext_move`=0, `ale` stays low for the whole cycle. When `ext_move`=1, `ale` follows R2/R3 whatever the value of `ale_off`.
- R7: `p0_oe` is 1 in slots 0–2 of every cycle, and in slots 6–8 of fetch cycles only. When `p0_oe` is 1, `p0_out` carries bits [7:0] of the address for that half. When `p0_oe` is 0, `p0_out` is 0. The address is still driven in the clock where `ale` falls.
- R8: In a fetch cycle, the address for the first half (slots 0–5) is `acc_addr`, and for the second half (slots 6–11) it is `acc_addr`+1 modulo 2^16. `p2_out` shows bits [15:8] of the address for the current half.
- R9: In a data cycle, `p2_out` holds `acc_addr`[15:8] for the whole cycle when `cyc_wide`=1, and `p2_latch` when `cyc_wide`=0.
- R10: The cycle inputs (`cyc_xdata`, `cyc_wide`, `acc_addr`, `p2_latch`, `ale_off`, `ext_move`) are sampled only at the clock edge that leaves slot 11. Changes at other times have no effect on the outputs until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_xdata | input | 1 | Next machine cycle is an external data access |
| cyc_wide | input | 1 | Data access uses a 16-bit address (else 8-bit) |
| acc_addr | input | 16 | Fetch address or data address for the next cycle |
| p2_latch | input | 8 | Port-2 latch contents |
| ale_off | input | 1 | Keep the address-latch pulse quiet outside move instructions |
| ext_move | input | 1 | An external move instruction is executing |
| ale | output | 1 | Address-latch enable, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| p0_out | output | 8 | Low address byte drive on the shared port |
| p0_oe | output | 1 | Drive enable for the shared low port |
| p2_out | output | 8 | High address port value |

## Verification
The bench aims at the cycle kinds that change the strobe pattern. A design that emits the second latch pulse in a data cycle, or that gives a program read during one, would corrupt the latched address or read code onto the data bus. A second-half fetch at an address ending in FFh checks that the carry reaches the high port; a design that reused the first-half high byte would fetch from the wrong page. The cases with `ale_off` set, both with and without a move instruction, show whether the gate silences the pulse only where it should. Inputs are also scrambled in the middle of a cycle, which exposes a design that samples them more than once per cycle. A reset in the middle of a cycle checks that the strobes go quiet and that the slot count starts again.

// File: rtl/emem_pkg.sv
package emem_pkg;

    // Cycle geometry
    localparam int CYCLE_CLKS = 12;
    localparam int HALF_CLKS  = CYCLE_CLKS / 2;
    localparam int ALE_CLKS   = 2;
    localparam int PSEN_FIRST = HALF_CLKS / 2;
    localparam int PH_W       = $clog2(CYCLE_CLKS);

    // Bus widths
    localparam int ADDR_W = 16;
    localparam int LO_W   = 8;
    localparam int HI_W   = ADDR_W - LO_W;

    typedef logic [PH_W-1:0]   ph_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LO_W-1:0]   lo_t;
    typedef logic [HI_W-1:0]   hi_t;

    localparam ph_t PH_LAST   = ph_t'(CYCLE_CLKS - 1);
    localparam ph_t PH_HALF   = ph_t'(HALF_CLKS);
    localparam ph_t ALE_END   = ph_t'(ALE_CLKS);
    localparam ph_t PSEN_OFF0 = ph_t'(PSEN_FIRST);

    // What one machine cycle does, captured once per cycle
    typedef struct packed {
        logic  xdata;
        logic  wide;
        addr_t addr;
        hi_t   p2;
        logic  ale_off;
        logic  move;
    } mc_info_t;

    function automatic logic ph_second_half(input ph_t ph);
        return ph >= PH_HALF;
    endfunction

    function automatic ph_t ph_offset(input ph_t ph);
        return ph_second_half(ph) ? ph - PH_HALF : ph;
    endfunction

endpackage

// File: rtl/emem_sequencer.sv
module emem_sequencer
    import emem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mc_info_t in_info,
    output ph_t      nxt_ph,
    output mc_info_t nxt_info
);

    ph_t      ph_q;
    mc_info_t info_q;
    logic     wrap;

    assign wrap = (ph_q == PH_LAST);

    always_comb begin
        if (rst) begin
            nxt_ph   = '0;
            nxt_info = '0;
        end else begin
            nxt_ph   = wrap ? '0 : ph_q + ph_t'(1);
            nxt_info = wrap ? in_info : info_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            info_q <= '0;
        end else begin
            ph_q   <= nxt_ph;
            info_q <= nxt_info;
        end
    end

endmodule

// File: rtl/emem_strobes.sv
module emem_strobes
    import emem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ph_t  nxt_ph,
    input  logic xdata,
    input  logic ale_gate,
    output logic ale,
    output logic psen_n
);

    logic half;
    ph_t  off;
    logic ale_d;
    logic psen_d;

    always_comb begin
        half   = ph_second_half(nxt_ph);
        off    = ph_offset(nxt_ph);
        ale_d  = ale_gate && (off < ALE_END) && (!half || !xdata);
        psen_d = !xdata && (off >= PSEN_OFF0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ale    <= 1'b0;
            psen_n <= 1'b1;
        end else begin
            ale    <= ale_d;
            psen_n <= !psen_d;
        end
    end

endmodule

// File: rtl/emem_addr_port.sv
module emem_addr_port
    import emem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ph_t   nxt_ph,
    input  logic  xdata,
    input  logic  wide,
    input  addr_t addr,
    input  hi_t   p2_latch,
    output lo_t   p0_out,
    output logic  p0_oe,
    output hi_t   p2_out
);

    logic  half;
    ph_t   off;
    addr_t fetch_addr;
    addr_t drv_addr;
    logic  addr_slot;
    hi_t   p2_d;

    always_comb begin
        half       = ph_second_half(nxt_ph);
        off        = ph_offset(nxt_ph);
        fetch_addr = addr + addr_t'(half);
        drv_addr   = xdata ? addr : fetch_addr;
        addr_slot  = (off <= ALE_END) && (!half || !xdata);
        if (!xdata)
            p2_d = fetch_addr[ADDR_W-1:LO_W];
        else if (wide)
            p2_d = addr[ADDR_W-1:LO_W];
        else
            p2_d = p2_latch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p0_out <= '0;
            p0_oe  <= 1'b0;
            p2_out <= '0;
        end else begin
            p0_out <= addr_slot ? drv_addr[LO_W-1:0] : '0;
            p0_oe  <= addr_slot;
            p2_out <= p2_d;
        end
    end

endmodule

// File: rtl/emem_bus_strobes.sv
module emem_bus_strobes
    import emem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_xdata,
    input  logic              cyc_wide,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [HI_W-1:0]   p2_latch,
    input  logic              ale_off,
    input  logic              ext_move,
    output logic              ale,
    output logic              psen_n,
    output logic [LO_W-1:0]   p0_out,
    output logic              p0_oe,
    output logic [HI_W-1:0]   p2_out
);

    mc_info_t in_info;
    mc_info_t nxt_info;
    ph_t      nxt_ph;
    logic     ale_gate;

    always_comb begin
        in_info.xdata   = cyc_xdata;
        in_info.wide    = cyc_wide;
        in_info.addr    = acc_addr;
        in_info.p2      = p2_latch;
        in_info.ale_off = ale_off;
        in_info.move    = ext_move;
        ale_gate        = !nxt_info.ale_off || nxt_info.move;
    end

    emem_sequencer i_seq (
        .clk      (clk),
        .rst      (rst),
        .in_info  (in_info),
        .nxt_ph   (nxt_ph),
        .nxt_info (nxt_info)
    );

    emem_strobes i_strb (
        .clk      (clk),
        .rst      (rst),
        .nxt_ph   (nxt_ph),
        .xdata    (nxt_info.xdata),
        .ale_gate (ale_gate),
        .ale      (ale),
        .psen_n   (psen_n)
    );

    emem_addr_port i_port (
        .clk      (clk),
        .rst      (rst),
        .nxt_ph   (nxt_ph),
        .xdata    (nxt_info.xdata),
        .wide     (nxt_info.wide),
        .addr     (nxt_info.addr),
        .p2_latch (nxt_info.p2),
        .p0_out   (p0_out),
        .p0_oe    (p0_oe),
        .p2_out   (p2_out)
    );

endmodule

// File: rtl/emem_bus_checker.sv
module emem_bus_checker
    import emem_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      ale,
    input logic      psen_n,
    input logic [LO_W-1:0] p0_out,
    input logic      p0_oe
);

    // R1: one clock of reset leaves every strobe quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (psen_n && !ale && !p0_oe));

    // R4: latch pulse and program read never overlap
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        !(ale && !psen_n));

    // R4: a program read starts only after the latch pulse is over
    p_psen_after_ale_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |-> ($past(!ale) && !p0_oe));

    // R7: address still driven and unchanged when the latch pulse ends
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> (p0_oe && $stable(p0_out)));

    // R7: low port is released while code is being read
    p_port_free_r7: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> !p0_oe);

endmodule

bind emem_bus_strobes emem_bus_checker i_chk (
    .clk    (clk),
    .rst    (rst),
    .ale    (ale),
    .psen_n (psen_n),
    .p0_out (p0_out),
    .p0_oe  (p0_oe)
);

// File: tb/test_emem_bus_strobes.sv
module test_emem_bus_strobes;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_xdata = 1'b0;
    logic        cyc_wide = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  p2_latch = '0;
    logic        ale_off = 1'b0;
    logic        ext_move = 1'b0;
    logic        ale;
    logic        psen_n;
    logic [7:0]  p0_out;
    logic        p0_oe;
    logic [7:0]  p2_out;

    int checks = 0;
    int errors = 0;
    string scen = "reset";

    // Behavioural reference state
    int mph = 0;
    bit mx, mw, maof, mmov;
    int maddr, mp2;
    bit e_ale, e_psen_n, e_oe;
    int e_p0, e_p2;
    bit in_rst;

    always #5 clk = ~clk;

    emem_bus_strobes i_emem_bus_strobes (
        .clk(clk), .rst(rst), .cyc_xdata(cyc_xdata), .cyc_wide(cyc_wide),
        .acc_addr(acc_addr), .p2_latch(p2_latch), .ale_off(ale_off),
        .ext_move(ext_move), .ale(ale), .psen_n(psen_n), .p0_out(p0_out),
        .p0_oe(p0_oe), .p2_out(p2_out)
    );

    task automatic model_update();
        in_rst = rst;
        if (rst) begin
            mph = 0; mx = 0; mw = 0; maof = 0; mmov = 0; maddr = 0; mp2 = 0;
            e_ale = 0; e_psen_n = 1; e_oe = 0; e_p0 = 0; e_p2 = 0;
        end else begin
            int half, off, fa, da;
            if (mph == 11) begin
                mph = 0;
                mx = cyc_xdata; mw = cyc_wide; maof = ale_off; mmov = ext_move;
                maddr = acc_addr; mp2 = p2_latch;
            end else begin
                mph++;
            end
            half = mph / 6;
            off  = mph % 6;
            fa   = (maddr + half) & 16'hFFFF;
            da   = mx ? maddr : fa;
            e_ale    = (!maof || mmov) && off < 2 && (half == 0 || !mx);
            e_psen_n = !(off >= 3 && !mx);
            e_oe     = off <= 2 && (half == 0 || !mx);
            e_p0     = e_oe ? (da & 8'hFF) : 0;
            e_p2     = mx ? (mw ? (maddr >> 8) : mp2) : (fa >> 8);
        end
    endtask

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s [%s] %s: got %0h expected %0h slot %0d",
                     tag, scen, what, got, exp, mph);
        end
    endtask

    task automatic compare();
        string t_ale, t_ps, t_p0, t_p2;
        if (in_rst) begin
            t_ale = "R1"; t_ps = "R1"; t_p0 = "R1"; t_p2 = "R1";
        end else if (scen == "glitch") begin
            t_ale = "R10"; t_ps = "R10"; t_p0 = "R10"; t_p2 = "R10";
        end else begin
            t_ale = (maof && !mmov) ? "R6" : (mx ? "R3" : "R2");
            t_ps  = mx ? "R5" : "R4";
            t_p0  = "R7";
            t_p2  = mx ? "R9" : "R8";
        end
        chk(t_ale, "ale", int'(ale), int'(e_ale));
        chk(t_ps, "psen_n", int'(psen_n), int'(e_psen_n));
        chk(t_p0, "p0_oe", int'(p0_oe), int'(e_oe));
        chk(t_p0, "p0_out", int'(p0_out), e_p0);
        chk(t_p2, "p2_out", int'(p2_out), e_p2);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        compare();
    endtask

    // Called with the design sitting in slot 11: inputs are taken at the next edge
    task automatic run_cycle(string name, bit x, bit w, int a, int p2, bit aof,
                             bit mv, bit glitch);
        scen = name;
        cyc_xdata = x; cyc_wide = w; acc_addr = 16'(a); p2_latch = 8'(p2);
        ale_off = aof; ext_move = mv;
        step();
        if (glitch) begin
            // R10: scrambled inputs mid-cycle must not reach the outputs
            cyc_xdata = ~x; cyc_wide = ~w; acc_addr = ~16'(a);
            p2_latch = ~8'(p2); ale_off = ~aof; ext_move = ~mv;
        end
        for (int i = 0; i < 11; i++) step();
    endtask

    initial begin
        // R1: reset state
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        scen = "first";
        for (int i = 0; i < 11; i++) step();
        run_cycle("fetch",        0, 0, 16'h1234, 8'h00, 0, 0, 0); // R2 R4 R7 R8
        run_cycle("fetch_carry",  0, 0, 16'h12FF, 8'h00, 0, 0, 0); // R8
        run_cycle("data_wide",    1, 1, 16'hABCD, 8'h5A, 0, 0, 0); // R3 R5 R9
        run_cycle("data_narrow",  1, 0, 16'h0055, 8'h7E, 0, 0, 0); // R9
        run_cycle("fetch_wrap",   0, 0, 16'hFFFF, 8'h00, 0, 0, 0); // R8
        run_cycle("gate_fetch",   0, 0, 16'h4000, 8'h11, 1, 0, 0); // R6
        run_cycle("gate_data",    1, 1, 16'h8001, 8'h22, 1, 0, 0); // R6
        run_cycle("gate_move",    1, 1, 16'h9ABC, 8'h33, 1, 1, 0); // R6
        run_cycle("gate_movefet", 0, 0, 16'h00A0, 8'h44, 1, 1, 0); // R6
        run_cycle("glitch",       0, 0, 16'h2468, 8'h55, 0, 0, 1); // R10
        run_cycle("glitch",       1, 0, 16'h1357, 8'hC3, 0, 0, 1); // R10
        run_cycle("fetch",        0, 0, 16'h0F0F, 8'h00, 0, 0, 0);
        // Reset in the middle of a cycle, then restart (R1)
        scen = "mid_reset";
        for (int i = 0; i < 4; i++) step();
        rst = 1'b1;
        for (int i = 0; i < 2; i++) step();
        rst = 1'b0;
        for (int i = 0; i < 11; i++) step();
        run_cycle("after_reset",  1, 1, 16'hBEEF, 8'h66, 0, 0, 0);
        run_cycle("after_reset",  0, 0, 16'hCAFE, 8'h66, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule